// File: doc/BRIEF.md
# Masked Interrupt Collector with Vector Readout

This block gathers sixteen level-sensitive interrupt requests from local-bus peripherals into a single interrupt line for the processor. A status register tracks the request levels one clock behind the inputs. That status is ANDed with a software-owned enable mask, and the block raises its combined output while any enabled source is active.

Software talks to the block through a small register port. Each register is 16 bits wide, and a 32-bit bus access covers two neighbouring registers. The register at offset 0 is read-only. It returns a vector code for the lowest-numbered enabled source that is active: the source index plus one, shifted left by two. It returns zero when nothing is pending. The register at offset 2 holds the enable mask. Software can write it a byte at a time, and the byte that is not written keeps its value.

A handler reads the vector to find which source to serve. It clears the cause at the peripheral and reads again until the vector is zero. Requests are plain levels: the block does no edge capture and no nesting.

Top module: `irq_collector`

## Requirements
- R1: Every clock edge, each status bit takes the level of its request input. A source that goes high becomes visible one clock later, and a source that goes low disappears one clock later.
- R2: A source counts as pending only when both its status bit and its mask bit are 1. A source whose mask bit is 0 has no effect on the vector or on `irq_o`.
- R3: `irq_o` is a registered output. It is 1 when the pending set is non-zero. It takes the new value at the first clock edge after a change to the request inputs or to the mask, and it does not change before that edge.
- R4: Offset 0 reads as ((i+1) << 2), where i is the lowest pending source index. It reads 0 when nothing is pending. Bits 1:0 of a non-zero vector are always 0.
- R5: Offset 2 is the mask register, readable and writable. Byte enable 0 (the even byte address) writes bits 7:0 and byte enable 1 (the odd byte address) writes bits 15:8. A byte that is not enabled keeps its value.
- R6: A bus access at an even address `a` covers two registers. Data bits 15:0 and byte enables 1:0 apply to the register at `a`. Data bits 31:16 and byte enables 3:2 apply to the register at `a+2`. The read data uses the same split.
- R7: Writes to the vector register and to any offset other than 2 have no effect. Reads of any offset other than 0 and 2 return 0.
- R8: While `rst_ni` is low, the mask is 0x0010, the status is 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 16 | Level interrupt requests; bit n is source n |
| bus_addr_i | input | 4 | Byte address of the access; bit 0 is ignored |
| bus_we_i | input | 1 | Write strobe; the write is taken at the clock edge |
| bus_be_i | input | 4 | Byte enables for the two covered registers |
| bus_wdata_i | input | 32 | Write data; bits 31:16 go to the register at address+2 |
| bus_rdata_o | output | 32 | Read data for the addressed register pair, combinational |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
The vector is checked with every single source active alone, which shows whether each index maps to its own code. It is then checked with a fixed bit pattern shifted so that every index becomes the lowest of several active sources, which tells a correct lowest-first encoder apart from one that picks the highest source or ORs the codes. A sweep over many mask and request pairs compares the vector and `irq_o` with values computed from the AND of the two, which catches a mask that is ignored or inverted. Byte-lane writes at both halves of a 32-bit access, writes to the vector and to unused offsets, and the cycle just before and after a request change separate lane merging, lane routing, ignored writes and the one-clock latency of the output.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned REG_W = 16;
  localparam int unsigned BUS_W = 2 * REG_W;
  localparam int unsigned BE_W  = BUS_W / 8;

  typedef enum logic [1:0] {
    REG_VEC  = 2'd0,
    REG_MASK = 2'd1
  } reg_idx_e;

  function automatic logic [REG_W-1:0] vec_code(input int unsigned idx);
    logic [REG_W-1:0] c;
    c = REG_W'(idx + 1) << 2;
    return c;
  endfunction
endpackage

// File: rtl/irq_status_latch.sv
module irq_status_latch #(
  parameter int unsigned N_SRC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  output logic [N_SRC-1:0] status_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= '0;
    else         status_o <= req_i;
  end

  assert_status_follow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 (status_o == $past(req_i)));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] pend_i,
  output logic [REG_W-1:0] vec_o
);
  logic [N_SRC:0] seen;

  // seen[n] is 1 when some bit below n is pending
  assign seen[0] = 1'b0;
  for (genvar n = 0; n < N_SRC; n++) begin : g_chain
    assign seen[n+1] = seen[n] | pend_i[n];
  end

  always_comb begin
    vec_o = '0;
    for (int n = 0; n < N_SRC; n++) begin
      if (pend_i[n] && !seen[n]) vec_o = vec_code(n);
    end
  end

  assert_vec_align_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_o[1:0] == 2'b00);
  assert_vec_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i == '0) |-> (vec_o == '0));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC    = 16,
  parameter logic [REG_W-1:0] MASK_RST = 16'h0010
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             hit_lo_i,
  input  logic             hit_hi_i,
  input  logic [BE_W-1:0]  be_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [N_SRC-1:0] mask_o,
  output logic [N_SRC-1:0] mask_d_o
);
  localparam int unsigned NB = REG_W / 8;

  logic [REG_W-1:0] mask_q, mask_d;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_comb begin
      mask_d[8*b +: 8] = mask_q[8*b +: 8];
      if (we_i && hit_lo_i && be_i[b])
        mask_d[8*b +: 8] = wdata_i[8*b +: 8];
      if (we_i && hit_hi_i && be_i[NB+b])
        mask_d[8*b +: 8] = wdata_i[REG_W + 8*b +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= MASK_RST;
    else         mask_q <= mask_d;
  end

  assign mask_o   = mask_q[N_SRC-1:0];
  assign mask_d_o = mask_d[N_SRC-1:0];

  assert_mask_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (hit_lo_i || hit_hi_i)) |=> $stable(mask_q));
  assert_lane_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_lo_i && !hit_hi_i && !be_i[1]) |=> (mask_q[15:8] == $past(mask_q[15:8])));
endmodule

// File: rtl/irq_collector.sv
module irq_collector
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC    = 16,
  parameter int unsigned ADDR_W   = 4,
  parameter logic [REG_W-1:0] MASK_RST = 16'h0010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  req_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [BE_W-1:0]   bus_be_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              irq_o
);
  localparam int unsigned IDX_W = ADDR_W;  // halfword index plus one carry bit

  logic [N_SRC-1:0] status_q, mask_q, mask_d, pend;
  logic [REG_W-1:0] vec;
  logic [IDX_W-1:0] lo_idx, hi_idx;
  logic             hit_lo, hit_hi;

  assign lo_idx = IDX_W'(bus_addr_i[ADDR_W-1:1]);
  assign hi_idx = lo_idx + IDX_W'(1);
  assign hit_lo = (lo_idx == IDX_W'(REG_MASK));
  assign hit_hi = (hi_idx == IDX_W'(REG_MASK));

  irq_status_latch #(.N_SRC(N_SRC)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .status_o (status_q)
  );

  irq_mask_reg #(.N_SRC(N_SRC), .MASK_RST(MASK_RST)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (bus_we_i),
    .hit_lo_i (hit_lo),
    .hit_hi_i (hit_hi),
    .be_i     (bus_be_i),
    .wdata_i  (bus_wdata_i),
    .mask_o   (mask_q),
    .mask_d_o (mask_d)
  );

  assign pend = status_q & mask_q;

  irq_prio_enc #(.N_SRC(N_SRC)) u_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .vec_o  (vec)
  );

  function automatic logic [REG_W-1:0] rd_reg(input logic [IDX_W-1:0] idx,
                                              input logic [REG_W-1:0] v,
                                              input logic [N_SRC-1:0] m);
    logic [REG_W-1:0] r;
    r = '0;
    if (idx == IDX_W'(REG_VEC))  r = v;
    if (idx == IDX_W'(REG_MASK)) r = REG_W'(m);
    return r;
  endfunction

  always_comb begin
    bus_rdata_o[REG_W-1:0]     = rd_reg(lo_idx, vec, mask_q);
    bus_rdata_o[BUS_W-1:REG_W] = rd_reg(hi_idx, vec, mask_q);
  end

  // Registered from next-state values so irq_o tracks status_q & mask_q.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(req_i & mask_d);
  end

  assert_irq_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (vec != '0));
  assert_irq_masked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_i & mask_d) == '0) |=> !irq_o);
endmodule

// File: tb/tb_irq_collector.sv
`timescale 1ns/1ps
module tb_irq_collector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req = '0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_collector dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .bus_addr_i(addr),
    .bus_we_i(we), .bus_be_i(be), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_vec(input logic [15:0] p);
    logic [15:0] v;
    v = '0;
    for (int i = 15; i >= 0; i--) if (p[i]) v = 16'((i + 1) * 4);
    return v;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    addr = a; be = b; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; be = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic set_req(input logic [15:0] r);
    @(negedge clk);
    req = r;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    logic [15:0] m, r;

    // R8: values during and right after reset
    #20;
    rd(4'd0, d); chk("R8 vector in reset", d, 32'h0010_0000);
    chk("R8 irq in reset", {31'd0, irq}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    rd(4'd2, d); chk("R8 mask after reset", d, 32'h0000_0010);

    // R2: reset mask enables only source 4
    set_req(16'hFFEF);
    rd(4'd0, d); chk("R2 reset mask blocks", d[15:0], 32'd0);
    chk("R2 irq blocked", {31'd0, irq}, 32'd0);
    set_req(16'h0010);
    rd(4'd0, d); chk("R2 source 4 passes", d[15:0], 32'd20);

    // R5: full mask write
    wr(4'd2, 4'b0011, 32'h0000_FFFF);
    rd(4'd2, d); chk("R5 mask write", d, 32'h0000_FFFF);

    // R1/R4: each source alone
    for (int i = 0; i < 16; i++) begin
      set_req(16'(1) << i);
      rd(4'd0, d);
      chk($sformatf("R4 single src %0d", i), d, {16'hFFFF, 16'((i + 1) * 4)});
      chk($sformatf("R3 irq single %0d", i), {31'd0, irq}, 32'd1);
    end

    // R4: lowest of several
    for (int i = 0; i < 16; i++) begin
      r = (16'hA5C3 << i) | (16'(1) << i);
      set_req(r);
      rd(4'd0, d);
      chk($sformatf("R4 lowest %0d", i), d[15:0], 32'((i + 1) * 4));
    end

    // R1: removal of levels
    set_req(16'h0000);
    rd(4'd0, d); chk("R1 cleared vector", d[15:0], 32'd0);
    chk("R1 cleared irq", {31'd0, irq}, 32'd0);

    // R2/R3: mask and request sweep
    for (int k = 0; k < 24; k++) begin
      m = 16'(k * 16'h3A5) ^ 16'h5A5A;
      r = 16'(k * 16'h1F3 + 7) ^ 16'hC30C;
      wr(4'd2, 4'b0011, {16'h0, m});
      set_req(r);
      rd(4'd0, d);
      chk($sformatf("R2 sweep vec %0d", k), d, {m, exp_vec(r & m)});
      chk($sformatf("R3 sweep irq %0d", k), {31'd0, irq}, {31'd0, |(r & m)});
      wr(4'd2, 4'b0011, {16'h0, ~r});
      rd(4'd0, d);
      chk($sformatf("R2 masked out %0d", k), d[15:0], 32'd0);
    end

    // R3: latency of one clock
    wr(4'd2, 4'b0011, 32'h0000_FFFF);
    set_req(16'h0000);
    @(negedge clk); req = 16'h0100; #1;
    chk("R3 irq before edge", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R3 irq after edge", {31'd0, irq}, 32'd1);
    rd(4'd0, d); chk("R1 vector after edge", d[15:0], 32'd36);
    wr(4'd2, 4'b0011, 32'h0000_0000);
    chk("R3 mask clear drops irq", {31'd0, irq}, 32'd0);

    // R5: byte merge
    wr(4'd2, 4'b0011, 32'h0000_FFFF);
    wr(4'd2, 4'b0001, 32'h0000_0012);
    rd(4'd2, d); chk("R5 low byte merge", d[15:0], 32'h0000_FF12);
    wr(4'd2, 4'b0010, 32'h0000_3400);
    rd(4'd2, d); chk("R5 high byte merge", d[15:0], 32'h0000_3412);

    // R6: upper half at addr 0 reaches mask
    wr(4'd0, 4'b1100, 32'hABCD_0000);
    rd(4'd0, d); chk("R6 upper half write", d[31:16], 32'h0000_ABCD);
    wr(4'd0, 4'b0100, 32'h0077_0000);
    rd(4'd2, d); chk("R6 upper byte lane", d[15:0], 32'h0000_AB77);

    // R7: ignored writes and zero reads
    wr(4'd0, 4'b0011, 32'h0000_FFFF);
    wr(4'd4, 4'b1111, 32'hFFFF_FFFF);
    wr(4'd14, 4'b1111, 32'h0000_0000);
    rd(4'd2, d); chk("R7 mask unchanged", d[15:0], 32'h0000_AB77);
    rd(4'd4, d); chk("R7 unused read", d, 32'd0);
    rd(4'd14, d); chk("R7 top read", d, 32'd0);
    rd(4'd0, d); chk("R7 vector unwritten", d[15:0], 32'd36);

    // R8: reset mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R8 irq reset", {31'd0, irq}, 32'd0);
    rd(4'd0, d); chk("R8 mask reset", d, 32'h0010_0000);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule